// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous true dual-port memory of 2048 bytes with two fully independent ports, called left and right. Each port has its own chip select, output enable, write enable, address and write data, and can read or write any location at any time. Read data is registered. It appears one cycle after the request and only when that request had both chip select and output enable high.

The two highest addresses also serve as mailboxes between the ports. Address 0x7FE belongs to the left port and address 0x7FF belongs to the right port. When one port writes into the other port's mailbox, an active-low interrupt is raised toward the receiver. The receiver then reads or otherwise accesses its own mailbox, and that access drops the interrupt. The byte stored in a mailbox is ordinary data. A global enable turns the mailbox function on or off. With the function off, the two addresses are plain memory.

Collision arbitration between the ports is not part of this block and belongs to a neighbouring block. Power-down behaviour is also outside it.

Top module: `mbox_dpram`

## Requirements
- R1: Either port can write any of the 2048 byte locations, and the written byte can be read back from either port.
- R2: A request with chip select and output enable high shows the addressed byte on that port's read data one cycle later. If a write to the same location happens in the same cycle, the read returns the old byte.
- R3: With the mailbox enable high, a right-port write (chip select and write enable high) to 0x7FE drives the left interrupt low on the next cycle. A left-port write to 0x7FE does not raise the left interrupt.
- R4: The left interrupt returns high on the cycle after a left-port access to 0x7FE with chip select and output enable both high, whatever the level of write enable. An access without output enable does not clear it.
- R5: With the mailbox enable high, a left-port write to 0x7FF drives the right interrupt low on the next cycle.
- R6: The right interrupt returns high on the cycle after a right-port access to 0x7FF with chip select and output enable both high, whatever the level of write enable.
- R7: The bytes at 0x7FE and 0x7FF are stored and read back like any other location.
- R8: With the mailbox enable low, no interrupt is raised, and 0x7FE and 0x7FF act only as memory.
- R9: A port whose chip select is low writes nothing, raises no interrupt and clears no interrupt.
- R10: Both interrupts are active low. A synchronous active-high reset drives both interrupts high and both read data outputs to zero.
- R11: When a set and a clear of the same interrupt fall in the same cycle, the set wins and the interrupt stays or goes low.
- R12: A port's read data is zero on the cycle after any cycle in which its chip select or output enable was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mbox_en | input | 1 | Mailbox interrupt function enable |
| l_cs | input | 1 | Left chip select, active high |
| l_oe | input | 1 | Left output enable, active high |
| l_we | input | 1 | Left write enable, active high |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs | input | 1 | Right chip select, active high |
| r_oe | input | 1 | Right output enable, active high |
| r_we | input | 1 | Right write enable, active high |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The mailbox function is tested with several kinds of access:
- Cross-port writes to each mailbox, which must raise the interrupt.
- A port writing to its own mailbox, which must not raise it.
- Clearing accesses with and without output enable, and with write enable high.
- Accesses with chip select low, which must have no effect.
- A set and a clear of the same interrupt in one cycle.
- The same traffic with the enable low.

Together these separate an interrupt driven by the correct port and strobe from one driven by any access to the address. Ordinary transfers between the ports, and a mailbox read that coincides with a write from the other port, show that the stored bytes and the read timing are unaffected by the interrupt logic.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int SIDE_LEFT  = 0;
  localparam int SIDE_RIGHT = 1;

  // Mailbox of a side: left owns the second-highest word, right the highest.
  function automatic int mbox_index(input int side, input int addr_w);
    return (1 << addr_w) - 2 + side;
  endfunction
endpackage

// File: rtl/mbox_mem.sv
module mbox_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_cs,
  input  logic              a_oe,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wd,
  output logic [DATA_W-1:0] a_rd,
  input  logic              b_cs,
  input  logic              b_oe,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wd,
  output logic [DATA_W-1:0] b_rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Both write ports in one process; same-address collisions are resolved elsewhere.
  always_ff @(posedge clk) begin
    if (a_cs && a_we) store[a_addr] <= a_wd;
    if (b_cs && b_we) store[b_addr] <= b_wd;
  end

  // Read-first output registers, zero when not selected.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_rd <= '0;
    end else if (a_cs && a_oe) begin
      a_rd <= store[a_addr];
    end else begin
      a_rd <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_rd <= '0;
    end else if (b_cs && b_oe) begin
      b_rd <= store[b_addr];
    end else begin
      b_rd <= '0;
    end
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag #(
  parameter int ADDR_W    = 11,
  parameter int MBOX_ADDR = 2046
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              peer_cs,
  input  logic              peer_we,
  input  logic [ADDR_W-1:0] peer_addr,
  input  logic              own_cs,
  input  logic              own_oe,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] MB = ADDR_W'(MBOX_ADDR);

  logic set_ev;
  logic clr_ev;

  assign set_ev = en && peer_cs && peer_we && (peer_addr == MB);
  assign clr_ev = own_cs && own_oe && (own_addr == MB);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1;
    end else if (set_ev) begin
      irq_n <= 1'b0;
    end else if (clr_ev) begin
      irq_n <= 1'b1;
    end
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mbox_en,
  input  logic              l_cs,
  input  logic              l_oe,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_cs,
  input  logic              r_oe,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);
  localparam int SIDES = 2;

  logic [SIDES-1:0] cs_v;
  logic [SIDES-1:0] oe_v;
  logic [SIDES-1:0] we_v;
  logic [SIDES-1:0] irq_v;
  logic [ADDR_W-1:0] addr_v [SIDES];

  assign cs_v = {r_cs, l_cs};
  assign oe_v = {r_oe, l_oe};
  assign we_v = {r_we, l_we};
  assign addr_v[SIDE_LEFT]  = l_addr;
  assign addr_v[SIDE_RIGHT] = r_addr;

  mbox_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .a_cs   (l_cs),
    .a_oe   (l_oe),
    .a_we   (l_we),
    .a_addr (l_addr),
    .a_wd   (l_wdata),
    .a_rd   (l_rdata),
    .b_cs   (r_cs),
    .b_oe   (r_oe),
    .b_we   (r_we),
    .b_addr (r_addr),
    .b_wd   (r_wdata),
    .b_rd   (r_rdata)
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_flag
    localparam int PEER = SIDES - 1 - g;
    mbox_flag #(
      .ADDR_W    (ADDR_W),
      .MBOX_ADDR (mbox_index(g, ADDR_W))
    ) u_flag (
      .clk       (clk),
      .rst       (rst),
      .en        (mbox_en),
      .peer_cs   (cs_v[PEER]),
      .peer_we   (we_v[PEER]),
      .peer_addr (addr_v[PEER]),
      .own_cs    (cs_v[g]),
      .own_oe    (oe_v[g]),
      .own_addr  (addr_v[g]),
      .irq_n     (irq_v[g])
    );
  end

  assign l_irq_n = irq_v[SIDE_LEFT];
  assign r_irq_n = irq_v[SIDE_RIGHT];
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mbox_en,
  input logic              l_cs,
  input logic              l_oe,
  input logic              l_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_wdata,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_irq_n,
  input logic              r_cs,
  input logic              r_oe,
  input logic              r_we,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_wdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] MB_L = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] MB_R = ADDR_W'((1 << ADDR_W) - 1);

  logic l_set, r_set, l_clr, r_clr;
  assign l_set = mbox_en && r_cs && r_we && (r_addr == MB_L);
  assign r_set = mbox_en && l_cs && l_we && (l_addr == MB_R);
  assign l_clr = l_cs && l_oe && (l_addr == MB_L);
  assign r_clr = r_cs && r_oe && (r_addr == MB_R);

  assert_left_set_R3: assert property (@(posedge clk) disable iff (rst)
    l_set |=> !l_irq_n);
  assert_left_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (l_clr && !l_set) |=> l_irq_n);
  assert_right_set_R5: assert property (@(posedge clk) disable iff (rst)
    r_set |=> !r_irq_n);
  assert_right_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (r_clr && !r_set) |=> r_irq_n);
  assert_off_no_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (!mbox_en && l_irq_n && r_irq_n) |=> (l_irq_n && r_irq_n));
  assert_left_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!l_set && !l_clr) |=> $stable(l_irq_n));
  assert_right_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!r_set && !r_clr) |=> $stable(r_irq_n));
  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0));
  assert_left_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !(l_cs && l_oe) |=> (l_rdata == '0));
  assert_right_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !(r_cs && r_oe) |=> (r_rdata == '0));
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_mbox_dpram.sv
module test_mbox_dpram;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst;
  logic mbox_en;
  logic l_cs, l_oe, l_we, r_cs, r_oe, r_we;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) i_mbox_dpram (.*);

  typedef struct packed {
    logic          lcs, loe, lwe;
    logic [AW-1:0] la;
    logic [DW-1:0] lw;
    logic          rcs, roe, rwe;
    logic [AW-1:0] ra;
    logic [DW-1:0] rw;
    logic          en;
    logic [DW-1:0] el, er;
    logic          eli, eri;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    // R1: plain writes from both sides
    '{1'b1,1'b0,1'b1,11'h005,8'hA5, 1'b1,1'b0,1'b1,11'h100,8'h3C, 1'b1, 8'h00,8'h00,1'b1,1'b1, 4'd1},
    // R1: cross reads
    '{1'b1,1'b1,1'b0,11'h100,8'h00, 1'b1,1'b1,1'b0,11'h005,8'h00, 1'b1, 8'h3C,8'hA5,1'b1,1'b1, 4'd1},
    // R3: right writes left mailbox
    '{1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1,1'b0,1'b1,11'h7FE,8'h5A, 1'b1, 8'h00,8'h00,1'b0,1'b1, 4'd3},
    // R4 / R7: left reads own mailbox, clears
    '{1'b1,1'b1,1'b0,11'h7FE,8'h00, 1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1, 8'h5A,8'h00,1'b1,1'b1, 4'd4},
    // R5: left writes right mailbox
    '{1'b1,1'b0,1'b1,11'h7FF,8'hC3, 1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1, 8'h00,8'h00,1'b1,1'b0, 4'd5},
    // R6 / R2: right access with write high clears, read-first
    '{1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1,1'b1,1'b1,11'h7FF,8'h11, 1'b1, 8'h00,8'hC3,1'b1,1'b1, 4'd6},
    // R2 / R7: new byte visible
    '{1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1,1'b1,1'b0,11'h7FF,8'h00, 1'b1, 8'h00,8'h11,1'b1,1'b1, 4'd2},
    // R8: disabled, right writes 7FE
    '{1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1,1'b0,1'b1,11'h7FE,8'h77, 1'b0, 8'h00,8'h00,1'b1,1'b1, 4'd8},
    // R8: disabled, stored as memory
    '{1'b1,1'b1,1'b0,11'h7FE,8'h00, 1'b0,1'b0,1'b0,11'h000,8'h00, 1'b0, 8'h77,8'h00,1'b1,1'b1, 4'd8},
    // R9: right unselected write
    '{1'b0,1'b0,1'b0,11'h000,8'h00, 1'b0,1'b0,1'b1,11'h7FE,8'h99, 1'b1, 8'h00,8'h00,1'b1,1'b1, 4'd9},
    // R9: nothing was written
    '{1'b1,1'b1,1'b0,11'h7FE,8'h00, 1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1, 8'h77,8'h00,1'b1,1'b1, 4'd9},
    // R3: set again
    '{1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1,1'b0,1'b1,11'h7FE,8'h42, 1'b1, 8'h00,8'h00,1'b0,1'b1, 4'd3},
    // R9 / R12: left unselected access does not clear
    '{1'b0,1'b1,1'b0,11'h7FE,8'h00, 1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1, 8'h00,8'h00,1'b0,1'b1, 4'd9},
    // R4 / R12: no output enable, no clear
    '{1'b1,1'b0,1'b0,11'h7FE,8'h00, 1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1, 8'h00,8'h00,1'b0,1'b1, 4'd4},
    // R11: clear and set together, set wins; read-first returns 42
    '{1'b1,1'b1,1'b0,11'h7FE,8'h00, 1'b1,1'b0,1'b1,11'h7FE,8'h24, 1'b1, 8'h42,8'h00,1'b0,1'b1, 4'd11},
    // R4: clear
    '{1'b1,1'b1,1'b0,11'h7FE,8'h00, 1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1, 8'h24,8'h00,1'b1,1'b1, 4'd4},
    // R3: own mailbox write does not raise
    '{1'b1,1'b0,1'b1,11'h7FE,8'h66, 1'b0,1'b0,1'b0,11'h000,8'h00, 1'b1, 8'h00,8'h00,1'b1,1'b1, 4'd3},
    // R1 / R7: both read the mailbox
    '{1'b1,1'b1,1'b0,11'h7FE,8'h00, 1'b1,1'b1,1'b0,11'h7FE,8'h00, 1'b1, 8'h66,8'h66,1'b1,1'b1, 4'd1}
  };

  function automatic string rname(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    l_cs = 0; l_oe = 0; l_we = 0; l_addr = '0; l_wdata = '0;
    r_cs = 0; r_oe = 0; r_we = 0; r_addr = '0; r_wdata = '0;
  endtask

  initial begin
    idle();
    mbox_en = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "l_irq_n", l_irq_n, 1);
    check("R10", "r_irq_n", r_irq_n, 1);
    check("R10", "l_rdata", l_rdata, 0);
    check("R10", "r_rdata", r_rdata, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      l_cs = VEC[i].lcs; l_oe = VEC[i].loe; l_we = VEC[i].lwe;
      l_addr = VEC[i].la; l_wdata = VEC[i].lw;
      r_cs = VEC[i].rcs; r_oe = VEC[i].roe; r_we = VEC[i].rwe;
      r_addr = VEC[i].ra; r_wdata = VEC[i].rw;
      mbox_en = VEC[i].en;
      @(negedge clk);
      check(rname(int'(VEC[i].req)), $sformatf("v%0d l_rdata", i), l_rdata, VEC[i].el);
      check(rname(int'(VEC[i].req)), $sformatf("v%0d r_rdata", i), r_rdata, VEC[i].er);
      check(rname(int'(VEC[i].req)), $sformatf("v%0d l_irq_n", i), l_irq_n, VEC[i].eli);
      check(rname(int'(VEC[i].req)), $sformatf("v%0d r_irq_n", i), r_irq_n, VEC[i].eri);
    end

    // R12: read data drops to zero once the port is idle
    idle();
    @(negedge clk);
    check("R12", "l_rdata idle", l_rdata, 0);
    check("R12", "r_rdata idle", r_rdata, 0);

    // R5 then R10: raise both flags, reset returns them high
    mbox_en = 1'b1;
    l_cs = 1; l_we = 1; l_addr = 11'h7FF; l_wdata = 8'h01;
    r_cs = 1; r_we = 1; r_addr = 11'h7FE; r_wdata = 8'h02;
    @(negedge clk);
    check("R5", "r_irq_n both set", r_irq_n, 0);
    check("R3", "l_irq_n both set", l_irq_n, 0);
    idle();
    l_cs = 1; l_oe = 1; l_addr = 11'h7FF;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10", "l_irq_n after reset", l_irq_n, 1);
    check("R10", "r_irq_n after reset", r_irq_n, 1);
    check("R10", "l_rdata after reset", l_rdata, 0);
    idle();
    @(negedge clk);
    // R7: mailbox bytes survive reset as data
    l_cs = 1; l_oe = 1; l_addr = 11'h7FF;
    @(negedge clk);
    check("R7", "l_rdata 7FF", l_rdata, 8'h01);
    idle();
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule